// File: doc/BRIEF.md
# Pin Debounce Filter with Power-of-Two Windows

This block cleans up a set of already-synchronized pin inputs. Each pin has its own filter lane. A lane moves its filtered output to a new level only after the raw input has held that level, without interruption, for a stable window. The window is 2^code milliseconds, with a 3-bit code per pin, so it spans 1 ms to 128 ms. A per-pin enable selects the filter. When the enable is low, the raw level drives the output directly.

All lanes share one millisecond tick divider. The parameter `CLKS_PER_MS` sets how many clocks make one millisecond. A lane counts ticks only while its raw input differs from its filtered output. Any cycle in which the two agree clears the count.

Top module: `dbnc_filter`

## Requirements
- R1: After reset every filtered level is 0 and every window counter is cleared. An enabled pin whose raw input is 0 therefore reads 0 on `filt_o`.
- R2: The shared tick is active before the k-th rising clock edge after reset release exactly when k is a multiple of `CLKS_PER_MS`.
- R3: The window length in ticks is 1 << code. The code for pin p sits in bits [3p+2:3p] of `period_code_i`, and its values 0..7 give 1, 2, 4, ..., 128 ms.
- R4: In an enabled lane, a tick counts when it falls in a cycle where raw differs from the filtered level. The first such cycle of a window is included. The filtered level takes the raw value at the edge of the (1 << code)-th counted tick. At any other edge it holds.
- R5: Any enabled cycle in which raw equals the filtered level clears the count. This includes a reversal in the very cycle of the final tick, and no change is accepted then.
- R6: With `dbnc_en_i[p]` low, `filt_o[p]` equals `raw_i[p]` in the same cycle. The stored level follows raw, so after re-enabling, the output starts from the last raw level.
- R7: A lane samples its code in every cycle where it is idle (raw equals filtered level) or disabled. A code change during a running window only takes effect for the next window.
- R8: Lanes are independent: activity on one pin never alters another pin's output, and all lanes use the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | NUM_PINS | Synchronized raw pin levels |
| dbnc_en_i | input | NUM_PINS | Per-pin filter enable (0 = bypass) |
| period_code_i | input | 3*NUM_PINS | Per-pin window exponent, pin p at [3p+2:3p] |
| filt_o | output | NUM_PINS | Filtered pin levels |

## Verification
The sharpest coincidence is a raw reversal that lands in the same cycle as the tick that would close the window. The acceptance and the restart then compete at one edge. The bench provokes this by tracking the tick phase and the lane's count in its own model, and returning raw to the filtered level at exactly that cycle. It then checks that the output holds and that a fresh full window is needed afterwards. A code change landing in the same cycle a window is already running is also driven. There, the measured latency must match the old code, not the new one.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
    localparam int CODE_W = 3;
    // largest window is 2^(2^CODE_W - 1) ticks; counter needs 2^CODE_W bits
    localparam int CNT_W  = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic             filt;
        logic [CNT_W-1:0] cnt;
        code_t            code;
    } lane_st_t;
endpackage

// File: rtl/dbnc_ms_tick.sv
module dbnc_ms_tick #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int DIV_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_MS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.div == LAST) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.div == LAST);

    assert_div_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.div <= LAST);

    generate
        if (CLKS_PER_MS > 1) begin : g_spaced
            assert_tick_spaced_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/dbnc_lane.sv
module dbnc_lane
    import dbnc_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  tick_i,
    input  logic  raw_i,
    input  logic  en_i,
    input  code_t code_i,
    output logic  filt_o
);
    lane_st_t st_d, st_q;

    logic             same;
    logic [CNT_W:0]   win_len;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        same    = (raw_i == st_q.filt);
        win_len = (CNT_W + 1)'(1) << st_q.code;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        st_d    = st_q;
        if (!en_i) begin
            // bypass: stored level tracks raw, window idle
            st_d.filt = raw_i;
            st_d.cnt  = '0;
            st_d.code = code_i;
        end else if (same) begin
            // idle or interrupted: restart and pick up the current code
            st_d.cnt  = '0;
            st_d.code = code_i;
        end else if (tick_i) begin
            if (cnt_inc == win_len) begin
                st_d.filt = raw_i;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = en_i ? st_q.filt : raw_i;

    assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && raw_i == st_q.filt) |=> (st_q.cnt == '0));

    assert_hold_without_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(st_q.filt));

    assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, st_q.cnt} < win_len);

    assert_code_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && raw_i != st_q.filt) |=> $stable(st_q.code));

    assert_bypass_track_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (st_q.filt == $past(raw_i)));
endmodule

// File: rtl/dbnc_filter.sv
module dbnc_filter
    import dbnc_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int CLKS_PER_MS = 50000
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_PINS-1:0]        raw_i,
    input  logic [NUM_PINS-1:0]        dbnc_en_i,
    input  logic [NUM_PINS*CODE_W-1:0] period_code_i,
    output logic [NUM_PINS-1:0]        filt_o
);
    logic ms_tick;

    dbnc_ms_tick #(
        .CLKS_PER_MS(CLKS_PER_MS)
    ) u_tick (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(ms_tick)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
            dbnc_lane u_lane (
                .clk_i (clk_i),
                .rst_ni(rst_ni),
                .tick_i(ms_tick),
                .raw_i (raw_i[p]),
                .en_i  (dbnc_en_i[p]),
                .code_i(period_code_i[p*CODE_W +: CODE_W]),
                .filt_o(filt_o[p])
            );
        end
    endgenerate
endmodule

// File: tb/dbnc_filter_bench.sv
module dbnc_filter_bench;
    localparam int NP  = 4;
    localparam int CPM = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   raw = '0;
    logic [NP-1:0]   en = '0;
    logic [NP*3-1:0] code = '0;
    logic [NP-1:0]   filt;

    int    checks = 0;
    int    errors = 0;
    string req = "R1";
    bit    done = 1'b0;

    // reference model state
    int m_div;
    bit m_filt [NP];
    int m_cnt  [NP];
    int m_code [NP];

    always #10 clk = ~clk;

    dbnc_filter #(.NUM_PINS(NP), .CLKS_PER_MS(CPM)) u_dbnc_filter (
        .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .dbnc_en_i(en),
        .period_code_i(code), .filt_o(filt)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 0;
            for (int p = 0; p < NP; p++) begin
                m_filt[p] = 0; m_cnt[p] = 0; m_code[p] = 0;
            end
        end else begin
            bit tk;
            tk = (m_div == CPM - 1);
            m_div = tk ? 0 : m_div + 1;
            for (int p = 0; p < NP; p++) begin
                if (!en[p]) begin
                    m_filt[p] = raw[p]; m_cnt[p] = 0; m_code[p] = int'(code[p*3 +: 3]);
                end else if (raw[p] == m_filt[p]) begin
                    m_cnt[p] = 0; m_code[p] = int'(code[p*3 +: 3]);
                end else if (tk) begin
                    if (m_cnt[p] + 1 == (1 << m_code[p])) begin
                        m_filt[p] = raw[p]; m_cnt[p] = 0;
                    end else begin
                        m_cnt[p] = m_cnt[p] + 1;
                    end
                end
            end
        end
    end

    function automatic bit exp_out(int p);
        return en[p] ? m_filt[p] : raw[p];
    endfunction

    task automatic step();
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            checks++;
            if (filt[p] !== exp_out(p)) begin
                errors++;
                $display("FAIL %s pin %0d: actual %b expected %b", req, p, filt[p], exp_out(p));
            end
        end
    endtask

    task automatic check_val(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // flip pin p right after a tick edge, count cycles until accepted
    task automatic latency(int p, int c, int new_c, int at_cycle, output int n);
        code[p*3 +: 3] = 3'(c);
        step();
        while (m_div != 0) step();
        raw[p] = ~raw[p];
        n = 0;
        while (filt[p] != raw[p] && n < 2000) begin
            step();
            n++;
            if (n == at_cycle) code[p*3 +: 3] = 3'(new_c);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5eed));
        en = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state with all pins enabled and raw low
        req = "R1";
        repeat (3) step();
        check_val("R1 filt after reset", int'(filt), 0);

        // R2 R3 R4: latency equals CPM * 2^code when started just after a tick
        req = "R3";
        latency(0, 0, 0, 0, n); check_val("R2 code0 latency", n, CPM);
        latency(0, 2, 2, 0, n); check_val("R3 code2 latency", n, CPM * 4);
        latency(1, 7, 7, 0, n); check_val("R3 code7 latency", n, CPM * 128);
        req = "R4";
        latency(2, 1, 1, 0, n); check_val("R4 code1 latency", n, CPM * 2);

        // R7: code change mid-window does not shorten the running window
        req = "R7";
        latency(3, 3, 0, 5, n); check_val("R7 old code kept", n, CPM * 8);
        latency(3, 0, 0, 0, n); check_val("R7 new code used next", n, CPM);

        // R5: reversal on the final tick cancels acceptance
        req = "R5";
        code[0 +: 3] = 3'd1;
        step();
        raw[0] = ~raw[0];
        while (!(m_cnt[0] == 1 && m_div == CPM - 1)) step();
        raw[0] = ~raw[0];
        step();
        check_val("R5 no accept on reversal", int'(filt[0]), int'(raw[0]));
        check_val("R5 count cleared", m_cnt[0], 0);
        latency(0, 1, 1, 0, n); check_val("R5 full window after restart", n, CPM * 2);

        // R6: bypass passes raw through and seeds the stored level
        req = "R6";
        en[2] = 1'b0;
        for (int i = 0; i < 12; i++) begin
            raw[2] = 1'($urandom_range(0, 1));
            step();
        end
        raw[2] = 1'b1; step();
        en[2] = 1'b1;
        #1 check_val("R6 level after re-enable", int'(filt[2]), 1);
        step();

        // R8: random mix on all pins
        req = "R8";
        for (int i = 0; i < 8000; i++) begin
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(0, 15) == 0) raw[p] = ~raw[p];
                if ($urandom_range(0, 63) == 0) en[p] = ~en[p];
                if ($urandom_range(0, 31) == 0) code[p*3 +: 3] = 3'($urandom_range(0, 3));
            end
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule